// File: doc/BRIEF.md
# Transmit Inter-Frame Deferral Timer

This block tells an Ethernet MAC transmitter when it may start a new frame after the medium has been busy. It counts an inter-packet gap in bit times. The count advances only on a bit-time tick input, so the same logic works at any line rate. The gap has two parts. During the first part, in half duplex, carrier or a real collision still makes the transmitter defer: the count is held at zero while the activity lasts and starts again from zero once it ends. After the first part has elapsed, the block is committed and only its own TX_EN can restart the gap.

The two-part scheme can be switched off, which makes the first part zero bit times. In full duplex, carrier sense and collision have no effect, and the gap simply runs from the falling edge of TX_EN. In half duplex, a collision indication seen in the first 40 bit times of the gap is treated as a possible SQE test pulse and discarded. Nothing is reported or counted for it. Frame assembly, collision response and backoff are handled elsewhere. The only output is a permit flag.

Top module: `tx_gap_timer`

## Requirements
- R1: After a synchronous active-low reset, the gap count is zero and `tx_ok` is low until `ipg_len` ticks have been counted.
- R2: The gap count advances by one only in a cycle where `bit_tick` is 1. `tx_ok` rises once the count reaches `ipg_len`, and the count saturates there.
- R3: While `tx_en` is 1, `tx_ok` is 0 in the same cycle, and the gap count restarts from zero.
- R4: In half duplex (`full_duplex`=0), carrier (`crs`=1) seen while the count is below the effective first-part length holds the count at zero. The gap is counted again from zero afterwards.
- R5: In half duplex, carrier seen once the count has reached the effective first-part length does not affect the count or `tx_ok`.
- R6: In full duplex (`full_duplex`=1), `crs` and `col` never affect the count. The gap is timed only from the end of `tx_en`.
- R7: With `two_part_off`=1, the effective first-part length is 0, so `part1_len` and carrier are ignored. The full `ipg_len` is still enforced.
- R8: A `part1_len` larger than `ipg_len` is clamped to `ipg_len`. Carrier arriving at a saturated count therefore does not restart the gap.
- R9: In half duplex, `col` is ignored while the count is below 40. From count 40 up to the end of the first part, `col` defers exactly like carrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| tx_en | input | 1 | Own transmitter is sending |
| crs | input | 1 | Carrier sense |
| col | input | 1 | Collision indication |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| two_part_off | input | 1 | 1 = first deferral part forced to zero |
| ipg_len | input | CNT_W | Total gap length in bit times |
| part1_len | input | CNT_W | First-part length in bit times |
| tx_ok | output | 1 | Transmission permitted |

## Verification
The two functions that can meet in one cycle are the end of the first part and a late carrier or collision. Which one wins depends on whether the count is already at the effective first-part length on that edge. The bench provokes this by raising `crs` or `col` on a chosen tick index, one just below and one at the boundary. It covers the clamped case with a saturated count and the 40-bit collision blanking edge. The outcome is judged through `tx_ok` after a computed number of further ticks.

// File: rtl/tx_gap_pkg.sv
// Package: shared constants for the transmit inter-frame deferral timer.
// Assumes: gap lengths are expressed in bit times.
package tx_gap_pkg;
    // Length of the window after gap start in which a collision indication
    // is taken to be an SQE test pulse.
    localparam int unsigned SQE_BITS = 40;
endpackage

// File: rtl/tx_gap_limit.sv
// Module: tx_gap_limit
// Computes the effective first-part length: zero when the two-part scheme
// is off, otherwise the programmed value clamped to the total gap.
// Assumes: both lengths are static or change only between gaps.
module tx_gap_limit #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             two_part_off,
    input  logic [CNT_W-1:0] ipg_len,
    input  logic [CNT_W-1:0] part1_len,
    output logic [CNT_W-1:0] part1_eff
);
    // Select and clamp the first-part length.
    always_comb begin
        if (two_part_off)
            part1_eff = '0;
        else if (part1_len > ipg_len)
            part1_eff = ipg_len;
        else
            part1_eff = part1_len;
    end
endmodule

// File: rtl/tx_gap_medium.sv
// Module: tx_gap_medium
// Decides whether the running gap must restart: on own transmission always;
// in half duplex also on carrier or on a collision outside the SQE window,
// but only while the first part has not yet elapsed.
// Assumes: crs and col are already synchronous to clk.
module tx_gap_medium
    import tx_gap_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             tx_en,
    input  logic             crs,
    input  logic             col,
    input  logic             full_duplex,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] part1_eff,
    output logic             restart
);
    localparam logic [CNT_W-1:0] SQE_LIM = CNT_W'(SQE_BITS);

    logic in_part1;
    logic sqe_blank;
    logic defer;

    // Classify the gap position and form the restart request.
    always_comb begin
        in_part1  = cnt < part1_eff;
        sqe_blank = cnt < SQE_LIM;
        defer     = !full_duplex && in_part1 && (crs || (col && !sqe_blank));
        restart   = tx_en || defer;
    end
endmodule

// File: rtl/tx_gap_counter.sv
// Module: tx_gap_counter
// Counts bit-time ticks since the medium went idle, saturating at the gap
// length; a restart request clears it.
// Assumes: bit_tick is at most one cycle wide per bit time.
module tx_gap_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] ipg_len,
    output logic [CNT_W-1:0] cnt_q
);
    // Advance, clear or hold the gap count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= '0;
        else if (bit_tick && (cnt_q < ipg_len))
            cnt_q <= cnt_q + 1'b1;
    end

    // R3
    clear_on_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));

    // R2
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !bit_tick) |=> $stable(cnt_q));

    // R2
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && bit_tick) |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/tx_gap_timer.sv
// Module: tx_gap_timer (top)
// Two-part transmit inter-frame deferral timer: raises tx_ok once a full
// inter-packet gap of bit times has passed without a restart.
// Assumes: synchronous inputs, synchronous active-low reset.
module tx_gap_timer
    import tx_gap_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             tx_en,
    input  logic             crs,
    input  logic             col,
    input  logic             full_duplex,
    input  logic             two_part_off,
    input  logic [CNT_W-1:0] ipg_len,
    input  logic [CNT_W-1:0] part1_len,
    output logic             tx_ok
);
    localparam logic [CNT_W-1:0] SQE_LIM = CNT_W'(SQE_BITS);

    logic [CNT_W-1:0] part1_eff;
    logic [CNT_W-1:0] cnt;
    logic             restart;

    tx_gap_limit #(.CNT_W(CNT_W)) limit_i (
        .two_part_off (two_part_off),
        .ipg_len      (ipg_len),
        .part1_len    (part1_len),
        .part1_eff    (part1_eff)
    );

    tx_gap_medium #(.CNT_W(CNT_W)) medium_i (
        .tx_en       (tx_en),
        .crs         (crs),
        .col         (col),
        .full_duplex (full_duplex),
        .cnt         (cnt),
        .part1_eff   (part1_eff),
        .restart     (restart)
    );

    tx_gap_counter #(.CNT_W(CNT_W)) counter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .restart  (restart),
        .ipg_len  (ipg_len),
        .cnt_q    (cnt)
    );

    // Permit transmission once the gap is complete and the line is quiet.
    always_comb begin
        tx_ok = !tx_en && (cnt >= ipg_len);
    end

    // R3
    no_permit_while_sending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> !tx_ok);

    // R6
    full_duplex_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_duplex && !tx_en) |-> !restart);

    // R7
    one_part_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (two_part_off && !tx_en) |-> !restart);

    // R9
    sqe_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt < SQE_LIM) && !crs && !tx_en) |-> !restart);

    // R5
    committed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt >= part1_eff) && !tx_en) |-> !restart);

    // R8
    clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        part1_eff <= ipg_len);
endmodule

// File: tb/tx_gap_timer_tb_top.sv
// Bench for tx_gap_timer: a vector table walked by one loop, then
// directed tests for reset, tick gating and own-transmit restart.
module tx_gap_timer_tb_top;
    localparam int unsigned CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bit_tick = 1'b0;
    logic             tx_en = 1'b0;
    logic             crs = 1'b0;
    logic             col = 1'b0;
    logic             full_duplex = 1'b0;
    logic             two_part_off = 1'b0;
    logic [CNT_W-1:0] ipg_len = 8'd96;
    logic [CNT_W-1:0] part1_len = 8'd64;
    logic             tx_ok;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tx_gap_timer #(.CNT_W(CNT_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_tick     (bit_tick),
        .tx_en        (tx_en),
        .crs          (crs),
        .col          (col),
        .full_duplex  (full_duplex),
        .two_part_off (two_part_off),
        .ipg_len      (ipg_len),
        .part1_len    (part1_len),
        .tx_ok        (tx_ok)
    );

    // Vector fields: req(4) fd(1) off(1) ipg(8) p1(8) kind(2: 0 none,1 crs,2 col) at(8) n(8) exp(1)
    localparam int NV = 14;
    localparam logic [40:0] VEC [NV] = '{
        {4'd2, 1'b0, 1'b0, 8'd12, 8'd8,  2'd0, 8'd0,  8'd11,  1'b0}, // R2 one short
        {4'd2, 1'b0, 1'b0, 8'd12, 8'd8,  2'd0, 8'd0,  8'd12,  1'b1}, // R2 exact
        {4'd4, 1'b0, 1'b0, 8'd12, 8'd8,  2'd1, 8'd5,  8'd17,  1'b0}, // R4 restart, one short
        {4'd4, 1'b0, 1'b0, 8'd12, 8'd8,  2'd1, 8'd5,  8'd18,  1'b1}, // R4 restart, exact
        {4'd5, 1'b0, 1'b0, 8'd12, 8'd8,  2'd1, 8'd9,  8'd12,  1'b1}, // R5 late carrier
        {4'd6, 1'b1, 1'b0, 8'd12, 8'd8,  2'd1, 8'd5,  8'd12,  1'b1}, // R6 carrier in FD
        {4'd7, 1'b0, 1'b1, 8'd12, 8'd8,  2'd1, 8'd0,  8'd12,  1'b1}, // R7 carrier ignored
        {4'd7, 1'b0, 1'b1, 8'd12, 8'd8,  2'd0, 8'd0,  8'd11,  1'b0}, // R7 gap still enforced
        {4'd8, 1'b0, 1'b0, 8'd12, 8'd20, 2'd1, 8'd12, 8'd13,  1'b1}, // R8 saturated, clamped
        {4'd8, 1'b0, 1'b0, 8'd12, 8'd20, 2'd1, 8'd11, 8'd24,  1'b1}, // R8 just inside part 1
        {4'd9, 1'b0, 1'b0, 8'd60, 8'd50, 2'd2, 8'd30, 8'd60,  1'b1}, // R9 blanked collision
        {4'd9, 1'b0, 1'b0, 8'd60, 8'd50, 2'd2, 8'd45, 8'd60,  1'b0}, // R9 live collision
        {4'd9, 1'b0, 1'b0, 8'd60, 8'd50, 2'd2, 8'd45, 8'd106, 1'b1}, // R9 restart then full gap
        {4'd6, 1'b1, 1'b0, 8'd60, 8'd50, 2'd2, 8'd45, 8'd60,  1'b1}  // R6 collision in FD
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s tx_ok actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle of own transmission, then quiet.
    task automatic pulse_tx();
        @(negedge clk);
        tx_en = 1'b1; bit_tick = 1'b0; crs = 1'b0; col = 1'b0;
        @(negedge clk);
        tx_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1;
            @(negedge clk);
        end
        bit_tick = 1'b0;
    endtask

    // Watchdog: ends a hung run as a failure.
    initial begin
        for (int c = 0; c < 50000; c++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ipg_len = 8'd12; part1_len = 8'd8;
        check("R1", tx_ok, 1'b0);
        ticks(11);
        check("R1", tx_ok, 1'b0);
        ticks(1);
        check("R1", tx_ok, 1'b1);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            logic [3:0] req;
            logic [1:0] kind;
            logic [7:0] at, n;
            logic       exp;
            {req, full_duplex, two_part_off, ipg_len, part1_len, kind, at, n, exp} = VEC[v];
            pulse_tx();
            for (int i = 0; i < int'(n); i++) begin
                bit_tick = 1'b1;
                crs = (kind == 2'd1) && (i == int'(at));
                col = (kind == 2'd2) && (i == int'(at));
                @(negedge clk);
            end
            bit_tick = 1'b0; crs = 1'b0; col = 1'b0;
            check($sformatf("R%0d vector %0d", req, v), tx_ok, exp);
        end

        // R2: no advance without tick
        full_duplex = 1'b0; two_part_off = 1'b0;
        ipg_len = 8'd12; part1_len = 8'd8;
        pulse_tx();
        repeat (30) @(negedge clk);
        check("R2", tx_ok, 1'b0);
        ticks(12);
        check("R2", tx_ok, 1'b1);

        // R3: own transmission drops permit at once and restarts the gap
        tx_en = 1'b1;
        #1;
        check("R3", tx_ok, 1'b0);
        @(negedge clk);
        tx_en = 1'b0;
        ticks(1);
        check("R3", tx_ok, 1'b0);
        ticks(10);
        check("R3", tx_ok, 1'b0);
        ticks(1);
        check("R3", tx_ok, 1'b1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule